// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block copies a run of words between one peripheral and system memory while the processor keeps executing. Software loads a peripheral select value, a first memory word address, a word total and a direction into a small register set, then writes the start bit. From then on the engine works alone. For each word it waits until the peripheral says it is ready, then asks for the system bus. When the bus is granted it takes exactly one bus cycle to move one word, and then gives the bus back. The processor is held off the bus for that single cycle only. It takes no interrupt and does no context switch.

After every word the memory address goes up by one and the remaining total goes down by one. When the total is used up, the engine sets a done flag and drives an interrupt line high. Both stay high until software writes the control register again. A start request while the engine is running is dropped. A start with a total of zero finishes at once, without touching the bus.

Top module: `dma_cs`

## Requirements
- R1: After reset, `irq`, `bus_req` and `bus_valid` are low, and the status register reads 0.
- R2: Register offsets on `reg_addr`: 0 control (bit 0 start, bit 1 direction: 1 = memory to peripheral, 0 = peripheral to memory), 1 peripheral select, 2 memory address, 3 word total, 4 status (bit 0 busy, bit 1 done). Reads of offsets 2 and 3 return the live address and remaining total.
- R3: `bus_valid` is high only in the cycle that follows a cycle with both `bus_req` and `bus_gnt` high, and `bus_req` is low in that cycle.
- R4: Each bus ownership carries exactly one word: `bus_valid` is never high in two cycles in a row, and a block of N words gives exactly N `bus_valid` cycles.
- R5: `bus_req` rises only if `dev_ready` was high in the previous cycle. While `dev_ready` stays low, no request is made.
- R6: Word i of a block goes to memory address start+i. After the block, the memory address register reads start+N and the total reads 0.
- R7: In a peripheral-to-memory transfer, `bus_we` is 1, `bus_wdata` equals `dev_rdata` and `dev_wr` is 0. In a memory-to-peripheral transfer, `bus_we` is 0, `dev_wdata` equals `bus_rdata` and `dev_wr` is 1. In both cases `dev_strobe` is 1 and `dev_sel` shows the programmed peripheral select value.
- R8: At the end of the last word, busy drops and done and `irq` rise together. `irq` never rises while busy.
- R9: `irq` and done stay high until a control register write, which clears them.
- R10: While busy, every register write is ignored, including a start and a write that lands in a transfer cycle.
- R11: A start with a word total of 0 sets done and `irq` on the next edge, with no bus request. Done stays set even if that start write also clears an earlier done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| irq | output | 1 | Completion interrupt, level |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_valid | output | 1 | Engine owns the bus this cycle |
| bus_we | output | 1 | Memory write enable |
| bus_addr | output | AW | Memory word address |
| bus_wdata | output | DW | Memory write data |
| bus_rdata | input | DW | Memory read data, same cycle |
| dev_ready | input | 1 | Peripheral can take or supply a word |
| dev_sel | output | DEVW | Peripheral select value |
| dev_strobe | output | 1 | A word is exchanged with the peripheral |
| dev_wr | output | 1 | The peripheral receives the word |
| dev_rdata | input | DW | Word offered by the peripheral |
| dev_wdata | output | DW | Word delivered to the peripheral |

## Verification
A processor register write and a bus transfer can fall in the same cycle. The sharpest case is a write that arrives in the cycle where the last word is on the bus, which is also the cycle that raises completion. The bench forces grant and ready high so that this cycle can be predicted. It confirms that `bus_valid` is high at that moment, then writes a new memory address. It then expects the read-back address to be start+1, done and `irq` set, and the word stored at the original address. A second collision is a zero-total start whose control write also clears a pending done. There the bench expects `irq` to stay high and no request to appear.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_XFER = 2'd3
  } dma_state_e;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_DEV  = 3'd1;
  localparam logic [2:0] OFS_MEM  = 3'd2;
  localparam logic [2:0] OFS_CNT  = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;

  localparam int GO_BIT    = 0;
  localparam int DIR_BIT   = 1;
  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;
endpackage

// File: rtl/dma_cs_seq.sv
module dma_cs_seq
  import dma_cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cnt_zero,
  input  logic cnt_last,
  input  logic dev_ready,
  input  logic bus_gnt,
  output logic bus_req,
  output logic xfer,
  output logic finish,
  output logic busy
);
  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start && !cnt_zero) state_d = ST_WAIT;
      ST_WAIT: if (dev_ready)          state_d = ST_REQ;
      ST_REQ:  if (bus_gnt)            state_d = ST_XFER;
      ST_XFER: state_d = cnt_last ? ST_IDLE : ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign bus_req = (state_q == ST_REQ);
  assign xfer    = (state_q == ST_XFER);
  assign busy    = (state_q != ST_IDLE);
  assign finish  = (start && cnt_zero && (state_q == ST_IDLE)) || (xfer && cnt_last);
endmodule

// File: rtl/dma_cs_regs.sv
module dma_cs_regs
  import dma_cs_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 12,
  parameter int DEVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  input  logic            busy,
  input  logic            step,
  input  logic            finish,
  output logic            start,
  output logic            dir,
  output logic [DEVW-1:0] dev_id,
  output logic [AW-1:0]   mem_addr,
  output logic            cnt_zero,
  output logic            cnt_last,
  output logic            done
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] ADR_ONE = AW'(1);

  logic [AW-1:0]   mem_q, mem_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [DEVW-1:0] dev_q, dev_d;
  logic            dir_q, dir_d, done_q, done_d;
  logic            mem_en, cnt_en, dev_en, dir_en, done_en;
  logic            wr_ok, ctrl_wr;

  // writes only land while idle
  assign wr_ok   = reg_wr && !busy;
  assign ctrl_wr = wr_ok && (reg_addr == OFS_CTRL);
  assign start   = ctrl_wr && reg_wdata[GO_BIT];

  always_comb begin
    mem_en  = step || (wr_ok && (reg_addr == OFS_MEM));
    mem_d   = step ? (mem_q + ADR_ONE) : reg_wdata;
    cnt_en  = step || (wr_ok && (reg_addr == OFS_CNT));
    cnt_d   = step ? (cnt_q - CNT_ONE) : reg_wdata[CW-1:0];
    dev_en  = wr_ok && (reg_addr == OFS_DEV);
    dev_d   = reg_wdata[DEVW-1:0];
    dir_en  = ctrl_wr;
    dir_d   = reg_wdata[DIR_BIT];
    done_en = finish || ctrl_wr;
    done_d  = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= '0;
      cnt_q  <= '0;
      dev_q  <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (mem_en)  mem_q  <= mem_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (dev_en)  dev_q  <= dev_d;
      if (dir_en)  dir_q  <= dir_d;
      if (done_en) done_q <= done_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: reg_rdata[DIR_BIT]    = dir_q;
      OFS_DEV:  reg_rdata[DEVW-1:0]   = dev_q;
      OFS_MEM:  reg_rdata             = mem_q;
      OFS_CNT:  reg_rdata[CW-1:0]     = cnt_q;
      OFS_STAT: begin
        reg_rdata[STAT_BUSY] = busy;
        reg_rdata[STAT_DONE] = done_q;
      end
      default:  reg_rdata = '0;
    endcase
  end

  assign dir      = dir_q;
  assign dev_id   = dev_q;
  assign mem_addr = mem_q;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CNT_ONE);
  assign done     = done_q;
endmodule

// File: rtl/dma_cs_port.sv
module dma_cs_port #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int DEVW      = 4,
  parameter bit GATE_IDLE = 1'b1
) (
  input  logic            xfer,
  input  logic            dir,
  input  logic [AW-1:0]   mem_addr,
  input  logic [DEVW-1:0] dev_id,
  input  logic [DW-1:0]   dev_rdata,
  input  logic [DW-1:0]   bus_rdata,
  output logic            bus_valid,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic [DEVW-1:0] dev_sel,
  output logic            dev_strobe,
  output logic            dev_wr,
  output logic [DW-1:0]   dev_wdata
);
  assign bus_valid  = xfer;
  assign bus_we     = xfer && !dir;
  assign dev_strobe = xfer;
  assign dev_wr     = xfer && dir;

  generate
    if (GATE_IDLE) begin : g_gated
      // quiet bus lines outside the owned cycle
      assign bus_addr  = xfer ? mem_addr  : '0;
      assign bus_wdata = xfer ? dev_rdata : '0;
      assign dev_wdata = xfer ? bus_rdata : '0;
      assign dev_sel   = xfer ? dev_id    : '0;
    end else begin : g_open
      assign bus_addr  = mem_addr;
      assign bus_wdata = dev_rdata;
      assign dev_wdata = bus_rdata;
      assign dev_sel   = dev_id;
    end
  endgenerate
endmodule

// File: rtl/dma_cs.sv
module dma_cs
  import dma_cs_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int CW        = 12,
  parameter int DEVW      = 4,
  parameter bit GATE_IDLE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  output logic            irq,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic            bus_valid,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            dev_ready,
  output logic [DEVW-1:0] dev_sel,
  output logic            dev_strobe,
  output logic            dev_wr,
  input  logic [DW-1:0]   dev_rdata,
  output logic [DW-1:0]   dev_wdata
);
  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic            busy, xfer, finish, start, dir, cnt_zero, cnt_last, done;
  logic [DEVW-1:0] dev_id;
  logic [AW-1:0]   mem_addr;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dma_cs_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last),
    .dev_ready(dev_ready),
    .bus_gnt  (bus_gnt),
    .bus_req  (bus_req),
    .xfer     (xfer),
    .finish   (finish),
    .busy     (busy)
  );

  dma_cs_regs #(.AW(AW), .CW(CW), .DEVW(DEVW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy     (busy),
    .step     (xfer),
    .finish   (finish),
    .start    (start),
    .dir      (dir),
    .dev_id   (dev_id),
    .mem_addr (mem_addr),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last),
    .done     (done)
  );

  dma_cs_port #(.AW(AW), .DW(DW), .DEVW(DEVW), .GATE_IDLE(GATE_IDLE)) u_port (
    .xfer      (xfer),
    .dir       (dir),
    .mem_addr  (mem_addr),
    .dev_id    (dev_id),
    .dev_rdata (dev_rdata),
    .bus_rdata (bus_rdata),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .dev_sel   (dev_sel),
    .dev_strobe(dev_strobe),
    .dev_wr    (dev_wr),
    .dev_wdata (dev_wdata)
  );

  assign irq = done;
endmodule

// File: rtl/dma_cs_chk.sv
module dma_cs_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic bus_gnt,
  input logic bus_valid,
  input logic dev_ready,
  input logic irq,
  input logic busy
);
  a_r3_valid_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $past(bus_req && bus_gnt));

  a_r3_req_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !bus_req);

  a_r4_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> !bus_valid);

  a_r5_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(dev_ready));

  a_r8_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy);

  a_r8_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);
endmodule

bind dma_cs dma_cs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .bus_valid(bus_valid),
  .dev_ready(dev_ready),
  .irq      (irq),
  .busy     (busy)
);

// File: tb/dma_cs_test.sv
`timescale 1ns/1ps
module dma_cs_test;
  localparam int AW = 16, DW = 16, CW = 12, DEVW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, reg_wr, irq, bus_req, bus_gnt, bus_valid, bus_we;
  logic [2:0]      reg_addr;
  logic [AW-1:0]   reg_wdata, reg_rdata, bus_addr;
  logic [DW-1:0]   bus_wdata, bus_rdata, dev_rdata, dev_wdata;
  logic            dev_ready, dev_strobe, dev_wr;
  logic [DEVW-1:0] dev_sel;

  dma_cs #(.AW(AW), .DW(DW), .CW(CW), .DEVW(DEVW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dev_ready(dev_ready), .dev_sel(dev_sel),
    .dev_strobe(dev_strobe), .dev_wr(dev_wr), .dev_rdata(dev_rdata),
    .dev_wdata(dev_wdata)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'(i * 37 + 16'h4100);
  endfunction
  function automatic logic [DW-1:0] src_word(input int k);
    return DW'((k * 16'h0123) ^ 16'h5A5A);
  endfunction

  // memory and peripheral models
  logic [DW-1:0] mem  [0:255];
  logic [DW-1:0] sink [0:63];
  int src_idx, sink_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
      src_idx  <= 0;
      sink_idx <= 0;
    end else begin
      if (bus_valid && bus_we) mem[bus_addr[7:0]] <= bus_wdata;
      if (dev_strobe && !dev_wr) src_idx <= src_idx + 1;
      if (dev_strobe && dev_wr) begin
        sink[sink_idx % 64] <= dev_wdata;
        sink_idx <= sink_idx + 1;
      end
    end
  end
  assign bus_rdata = mem[bus_addr[7:0]];
  assign dev_rdata = src_word(src_idx);

  // bus/ready drivers and protocol monitor
  int gnt_mode = 0;   // 0 random, 1 low, 2 grant on request
  int rdy_mode = 0;   // 0 random, 1 low, 2 high
  logic [AW-1:0]   exp_addr = '0;
  logic [DEVW-1:0] exp_dev = '0;
  logic            exp_we = 1'b0;
  bit prev_hs = 0, prev_req = 0, prev_rdy = 0, req_seen = 0;
  int words_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_valid) begin
        check(prev_hs && !bus_req, "R3 valid after grant, req low", {31'd0, bus_req}, 32'd0);
        check(bus_addr == exp_addr, "R6 word address", 32'(bus_addr), 32'(exp_addr));
        check(dev_sel == exp_dev, "R7 peripheral select", 32'(dev_sel), 32'(exp_dev));
        check(bus_we == exp_we, "R7 write enable", {31'd0, bus_we}, {31'd0, exp_we});
        exp_addr = exp_addr + 1'b1;
        words_seen++;
      end
      if (bus_req && !prev_req)
        check(prev_rdy, "R5 ready before request", {31'd0, prev_rdy}, 32'd1);
      if (bus_req) req_seen = 1;
      prev_req = bus_req;
    end
    case (gnt_mode)
      0:       bus_gnt = bus_req && ($urandom % 3 != 0);
      1:       bus_gnt = 1'b0;
      default: bus_gnt = bus_req;
    endcase
    case (rdy_mode)
      0:       dev_ready = ($urandom % 3 != 0);
      1:       dev_ready = 1'b0;
      default: dev_ready = 1'b1;
    endcase
    prev_hs  = bus_req && bus_gnt;
    prev_rdy = dev_ready;
  end

  task automatic reg_write(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [AW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq(output bit ok);
    ok = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
  endtask

  int s0, k0;
  logic [DW-1:0] snap [0:15];

  task automatic setup(input logic [DEVW-1:0] dv, input logic [AW-1:0] st, input int n, input bit dr);
    exp_addr = st; exp_dev = dv; exp_we = !dr; words_seen = 0;
    s0 = src_idx; k0 = sink_idx;
    for (int i = 0; i < n; i++) snap[i] = mem[(int'(st) + i) % 256];
    reg_write(3'd1, AW'(dv));
    reg_write(3'd2, st);
    reg_write(3'd3, AW'(n));
  endtask

  task automatic finish_checks(input logic [AW-1:0] st, input int n, input bit dr);
    bit ok;
    logic [AW-1:0] v;
    wait_irq(ok);
    check(ok, "R8 irq after block", {31'd0, irq}, 32'd1);
    check(words_seen == n, "R4 one bus cycle per word", 32'(words_seen), 32'(n));
    reg_read(3'd4, v);
    check(v == 16'd2, "R8 status done, not busy", 32'(v), 32'd2);
    reg_read(3'd2, v);
    check(v == st + AW'(n), "R6 final address", 32'(v), 32'(st + AW'(n)));
    reg_read(3'd3, v);
    check(v == 16'd0, "R6 final total", 32'(v), 32'd0);
    for (int i = 0; i < n; i++) begin
      if (!dr)
        check(mem[(int'(st) + i) % 256] == src_word(s0 + i), "R7 word stored in memory",
              32'(mem[(int'(st) + i) % 256]), 32'(src_word(s0 + i)));
      else
        check(sink[(k0 + i) % 64] == snap[i], "R7 word delivered to peripheral",
              32'(sink[(k0 + i) % 64]), 32'(snap[i]));
    end
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R9 irq held until cleared", {31'd0, irq}, 32'd1);
    reg_write(3'd0, '0);
    check(irq == 1'b0, "R9 irq cleared by control write", {31'd0, irq}, 32'd0);
    reg_read(3'd4, v);
    check(v == 16'd0, "R9 done cleared", 32'(v), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    logic [AW-1:0] v;
    bit ok;
    void'($urandom(32'd2024));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    bus_gnt = 1'b0; dev_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(!irq && !bus_req && !bus_valid, "R1 outputs idle after reset",
          {29'd0, irq, bus_req, bus_valid}, 32'd0);
    reg_read(3'd4, v);
    check(v == 16'd0, "R1 status after reset", 32'(v), 32'd0);

    // R2 register readback
    reg_write(3'd1, 16'h000B);
    reg_read(3'd1, v);
    check(v == 16'h000B, "R2 peripheral select readback", 32'(v), 32'hB);
    reg_write(3'd0, 16'h0002);
    reg_read(3'd0, v);
    check(v == 16'h0002, "R2 direction readback", 32'(v), 32'h2);

    // directed transfers both ways, random grant and ready
    setup(4'd5, 16'h0010, 5, 1'b0);
    reg_write(3'd0, 16'h0001);
    finish_checks(16'h0010, 5, 1'b0);
    setup(4'd9, 16'h0010, 4, 1'b1);
    reg_write(3'd0, 16'h0003);
    finish_checks(16'h0010, 4, 1'b1);

    // R11 zero total, twice without clearing
    reg_write(3'd3, '0);
    reg_write(3'd2, 16'h0030);
    req_seen = 0;
    reg_write(3'd0, 16'h0001);
    check(irq == 1'b1, "R11 zero total finishes at once", {31'd0, irq}, 32'd1);
    reg_write(3'd0, 16'h0001);
    check(irq == 1'b1, "R11 done kept when start also clears", {31'd0, irq}, 32'd1);
    repeat (5) @(negedge clk);
    check(!req_seen, "R11 no bus request", {31'd0, req_seen}, 32'd0);
    reg_read(3'd2, v);
    check(v == 16'h0030, "R11 address untouched", 32'(v), 32'h30);
    reg_write(3'd0, '0);

    // R5 and R10: hold ready low, poke registers while busy
    rdy_mode = 1;
    setup(4'd6, 16'h0040, 3, 1'b0);
    req_seen = 0;
    reg_write(3'd0, 16'h0001);
    repeat (20) @(negedge clk);
    check(!req_seen, "R5 no request without ready", {31'd0, req_seen}, 32'd0);
    reg_write(3'd3, 16'd9);
    reg_write(3'd2, 16'h0099);
    reg_write(3'd1, 16'h0007);
    reg_write(3'd0, 16'h0003);
    reg_read(3'd3, v);
    check(v == 16'd3, "R10 total write ignored while busy", 32'(v), 32'd3);
    reg_read(3'd2, v);
    check(v == 16'h0040, "R10 address write ignored while busy", 32'(v), 32'h40);
    reg_read(3'd4, v);
    check(v == 16'd1, "R10 still busy", 32'(v), 32'd1);
    rdy_mode = 0;
    finish_checks(16'h0040, 3, 1'b0);

    // collision: register write in the transfer cycle of the last word
    gnt_mode = 2; rdy_mode = 2;
    setup(4'd3, 16'h0060, 1, 1'b0);
    reg_write(3'd0, 16'h0001);
    @(negedge clk);
    @(negedge clk);
    check(bus_valid == 1'b1, "R10 write placed in transfer cycle", {31'd0, bus_valid}, 32'd1);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h0055;
    @(negedge clk);
    reg_wr = 1'b0;
    check(irq == 1'b1, "R8 irq right after last word", {31'd0, irq}, 32'd1);
    reg_read(3'd2, v);
    check(v == 16'h0061, "R10 colliding write ignored", 32'(v), 32'h61);
    check(mem[8'h60] == src_word(s0), "R7 collided word stored",
          32'(mem[8'h60]), 32'(src_word(s0)));
    reg_write(3'd0, '0);
    gnt_mode = 0; rdy_mode = 0;

    // random blocks
    for (int it = 0; it < 10; it++) begin
      int n;
      bit dr;
      logic [AW-1:0] st;
      logic [DEVW-1:0] dv;
      n  = 1 + ($urandom % 8);
      dr = 1'($urandom % 2);
      st = AW'($urandom % 200);
      dv = DEVW'($urandom % 16);
      setup(dv, st, n, dr);
      reg_write(3'd0, {14'd0, dr, 1'b1});
      finish_checks(st, n, dr);
    end

    report();
  end
endmodule